// File: doc/BRIEF.md
# MDIO Management Master

This block is the serial engine behind a PHY management port. A host places a 16-bit value in the data register. It then writes a command word that gives the direction, the PHY address and the register address. The block builds the management frame and drives the clock and data pins until the frame is complete. While it works, a busy flag is set. When the flag drops, a read result is waiting in the data register.

The management clock is the system clock divided by a programmable divisor, which resets to 32. A level input sampled with the command can drop the 32-bit all-ones preamble, which shortens the frame from 64 bit periods to 32. The pins follow the usual split-driver scheme. `mdio_o` and `mdio_oe` feed an external tri-state pad, and the pad value comes back on `mdio_i`.

Top module: `mdio_master`

## Requirements
- R1: Command word layout: bits 4:0 hold the register address, bits 9:5 the PHY address, bit 10 requests a write and bit 11 a read. If both flags are set, the command is a read. A command with neither flag set is ignored and starts nothing.
- R2: `busy` rises in the cycle after an accepted command. It stays high for exactly (bit count × divisor) cycles and then falls.
- R3: A command written while `busy` is high is ignored, including one written in the last busy cycle.
- R4: Frame bits, in order: 32 ones (the preamble), start 0,1, opcode 1,0 for a read or 0,1 for a write, the PHY address MSB first, the register address MSB first, a two-bit turnaround, then 16 data bits MSB first. A write sends turnaround 1,0 followed by the data register value.
- R5: When `pre_sup` is high in the accepting cycle, the preamble is left out and the frame is 32 bit periods long.
- R6: Each bit period lasts divisor clocks. `mdc` is low for the first floor(divisor/2) clocks and high for the rest. `mdio_o` changes only at the start of a bit period.
- R7: The divisor resets to 32. A divisor write below 2, or one made while busy, is ignored. A divisor written in the same cycle as an accepted command applies to that command.
- R8: On a read, `mdio_oe` is low from the first turnaround bit to the end of the frame. `mdio_i` is sampled in the first clock of each high `mdc` phase during the 16 data bits. The word assembled from these samples is loaded into the data register when `busy` falls.
- R9: A data-register write while busy is ignored. A data write in the same cycle as an accepted command updates the register, but the frame carries the value held before that cycle.
- R10: When idle, `mdc` is low, `mdio_oe` is low and `mdio_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 12 | Command word (flags and addresses) |
| pre_sup | input | 1 | Omit the preamble for the command being written |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register write value |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | Divisor write value |
| busy | output | 1 | Transaction in progress |
| data_rdata | output | 16 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
Completion and a new command can meet in one cycle: the last busy cycle is also the cycle in which a host might write its next command. The bench waits until its model shows the final clock of a frame and writes a command on that exact edge. It then expects `busy` to fall and stay low, and expects no new frame to start. Command acceptance can also coincide with a data write and with a divisor write. The reference model settles these cases by rule: the frame carries the old data, the register takes the new data, and the frame runs at the new divisor. Every output is compared with the model on every clock.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [11:0]      cmd_wdata,
  input  logic             pre_sup,
  input  logic             data_we,
  input  logic [15:0]      data_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             busy,
  output logic [15:0]      data_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  localparam logic [5:0]       LAST_IDX = 6'd63;
  localparam logic [5:0]       PRE_SKIP = 6'd32;
  localparam logic [5:0]       TA_IDX   = 6'd46;
  localparam logic [5:0]       DAT_IDX  = 6'd48;
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);
  localparam logic [DIV_W-1:0] DIV_MIN  = DIV_W'(2);

  logic             rd_q;
  logic [63:0]      frame_q;
  logic [5:0]       idx_q;
  logic [DIV_W-1:0] cnt_q, div_q, half;
  logic [15:0]      data_q, sh_q, sh_nxt;
  logic             cmd_rd, accept, bit_end, done, sample;

  assign half    = div_q >> 1;
  assign cmd_rd  = cmd_wdata[11];
  assign accept  = cmd_we && !busy && (cmd_wdata[11] || cmd_wdata[10]);
  assign bit_end = (cnt_q == div_q - 1'b1);
  assign done    = busy && bit_end && (idx_q == LAST_IDX);
  assign sample  = busy && rd_q && (cnt_q == half) && (idx_q >= DAT_IDX);
  assign sh_nxt  = sample ? {sh_q[14:0], mdio_i} : sh_q;

  assign mdc        = busy && (cnt_q >= half);
  assign mdio_o     = busy ? frame_q[LAST_IDX - idx_q] : 1'b1;
  assign mdio_oe    = busy && !(rd_q && idx_q >= TA_IDX);
  assign data_rdata = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_q    <= 1'b0;
      frame_q <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      div_q   <= DIV_INIT;
      data_q  <= '0;
      sh_q    <= '0;
    end else begin
      if (accept) begin
        busy    <= 1'b1;
        rd_q    <= cmd_rd;
        idx_q   <= pre_sup ? PRE_SKIP : 6'd0;
        cnt_q   <= '0;
        frame_q <= {32'hFFFF_FFFF, 2'b01, cmd_rd ? 2'b10 : 2'b01, cmd_wdata[9:0],
                    cmd_rd ? 18'h3FFFF : {2'b10, data_q}};
      end else if (busy) begin
        if (bit_end) begin
          cnt_q <= '0;
          idx_q <= idx_q + 6'd1;
          if (idx_q == LAST_IDX) busy <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      sh_q <= sh_nxt;
      if (div_we && !busy && div_wdata >= DIV_MIN) div_q <= div_wdata;
      if (done && rd_q)            data_q <= sh_nxt;
      else if (data_we && !busy)   data_q <= data_wdata;
    end
  end

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_we)); // R2
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> $stable(frame_q)); // R3
  AST_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cnt_q != '0) |-> $stable(mdio_o)); // R6
  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    div_q >= DIV_MIN); // R7
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_rdata)); // R9
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (!mdio_oe && !mdc && mdio_o)); // R10

endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0, pre_sup = 1'b0, data_we = 1'b0, div_we = 1'b0, mdio_i = 1'b1;
  logic [11:0] cmd_wdata = '0;
  logic [15:0] data_wdata = '0;
  logic [DW-1:0] div_wdata = '0;
  logic busy, mdc, mdio_o, mdio_oe;
  logic [15:0] data_rdata;

  always #2.5 clk = ~clk;

  mdio_master #(.DIV_W(DW), .DIV_RESET(32)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .pre_sup(pre_sup),
    .data_we(data_we), .data_wdata(data_wdata), .div_we(div_we), .div_wdata(div_wdata),
    .busy(busy), .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  int errs = 0, checks = 0;
  string scen = "reset";

  bit m_active = 0, m_isrd = 0;
  int m_t = 0, m_total = 0, m_div = 32;
  logic [15:0] m_data = '0, m_rdval = '0;
  bit fr_v[$];
  bit fr_oe[$];

  function automatic logic [15:0] phy_val(logic [4:0] p, logic [4:0] r);
    return {p, r, 6'b100110} ^ 16'h3C5A;
  endfunction

  function automatic void put(bit v, bit oe);
    fr_v.push_back(v);
    fr_oe.push_back(oe);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, scen, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_t = 0; m_div = 32; m_data = '0;
    end else begin
      bit act;
      act = m_active;
      if (act) begin
        m_t++;
        if (m_t == m_total) begin
          m_active = 0;
          if (m_isrd) m_data = m_rdval;
        end
      end
      if (!act) begin
        if (div_we && div_wdata >= 2) m_div = int'(div_wdata);
        if (cmd_we && (cmd_wdata[11] || cmd_wdata[10])) begin
          m_isrd = cmd_wdata[11];
          fr_v.delete();
          fr_oe.delete();
          if (!pre_sup) repeat (32) put(1, 1);
          put(0, 1); put(1, 1);
          put(m_isrd, 1); put(!m_isrd, 1);
          for (int i = 9; i >= 0; i--) put(cmd_wdata[i], 1);
          if (m_isrd) begin put(1, 0); put(1, 0); end
          else begin put(1, 1); put(0, 1); end
          for (int i = 15; i >= 0; i--) put(m_isrd ? 1'b1 : m_data[i], !m_isrd);
          m_rdval  = phy_val(cmd_wdata[9:5], cmd_wdata[4:0]);
          m_total  = fr_v.size() * m_div;
          m_t      = 0;
          m_active = 1;
        end
        if (data_we) m_data = data_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int b, ph, nb;
      if (m_active) begin
        b  = m_t / m_div;
        ph = m_t % m_div;
        nb = fr_v.size();
        chk("R2 busy", 16'(busy), 16'd1);
        chk("R6 mdc", 16'(mdc), 16'(ph >= m_div / 2));
        chk(fr_oe[b] ? "R4 mdio_oe" : "R8 mdio_oe", 16'(mdio_oe), 16'(fr_oe[b]));
        if (fr_oe[b]) chk("R4 mdio_o", 16'(mdio_o), 16'(fr_v[b]));
        if (m_isrd && b >= nb - 16) mdio_i = m_rdval[15 - (b - (nb - 16))];
        else mdio_i = 1'b1;
      end else begin
        chk("R2 busy idle", 16'(busy), 16'd0);
        chk("R10 mdc idle", 16'(mdc), 16'd0);
        chk("R10 mdio_oe idle", 16'(mdio_oe), 16'd0);
        chk("R10 mdio_o idle", 16'(mdio_o), 16'd1);
        mdio_i = 1'b1;
      end
      chk("R9 data register", data_rdata, m_data);
    end
  end

  task automatic issue(logic [11:0] c, bit sup, bit dwe, logic [15:0] d, bit vwe, logic [DW-1:0] v);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = c; pre_sup = sup;
    data_we = dwe; data_wdata = d; div_we = vwe; div_wdata = v;
    @(negedge clk);
    cmd_we = 1'b0; data_we = 1'b0; div_we = 1'b0; pre_sup = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_active);
    @(negedge clk);
  endtask

  function automatic logic [11:0] mk(bit rd, bit wr, logic [4:0] p, logic [4:0] r);
    return {rd, wr, p, r};
  endfunction

  initial begin
    #750000;
    errs++; checks++;
    $display("FAIL watchdog expired [%s]", scen);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset busy", 16'(busy), 16'd0);
    chk("R9 reset data", data_rdata, 16'd0);

    scen = "R7 default divisor write";
    issue(12'd0, 0, 1, 16'h1234, 0, '0);
    issue(mk(0, 1, 5'd3, 5'd7), 0, 0, '0, 0, '0);
    chk("R2 busy after accept", 16'(busy), 16'd1);

    scen = "R3 R9 R7 writes while busy";
    issue(mk(1, 0, 5'd9, 5'd9), 0, 1, 16'hDEAD, 1, 8'd2);
    wait_idle();
    chk("R9 busy data write ignored", data_rdata, 16'h1234);

    scen = "R1 neither flag";
    issue(mk(0, 0, 5'd1, 5'd1), 0, 0, '0, 0, '0);
    repeat (3) @(negedge clk);
    chk("R1 no-flag command ignored", 16'(busy), 16'd0);

    scen = "R7 divisor below 2";
    issue(12'd0, 0, 0, '0, 1, 8'd1);

    scen = "R8 R7 read with divisor written alongside";
    issue(mk(1, 0, 5'd5, 5'd2), 0, 0, '0, 1, 8'd4);
    wait_idle();
    chk("R8 read result", data_rdata, phy_val(5'd5, 5'd2));

    scen = "R5 R6 suppressed read odd divisor";
    issue(12'd0, 0, 0, '0, 1, 8'd3);
    issue(mk(1, 0, 5'd31, 5'd17), 1, 0, '0, 0, '0);
    wait_idle();
    chk("R5 short read result", data_rdata, phy_val(5'd31, 5'd17));

    scen = "R1 both flags read";
    issue(mk(1, 1, 5'd12, 5'd30), 0, 0, '0, 1, 8'd5);
    wait_idle();
    chk("R1 both flags gives read", data_rdata, phy_val(5'd12, 5'd30));

    scen = "R9 data write with command";
    issue(mk(0, 1, 5'd6, 5'd1), 0, 1, 16'hBEEF, 1, 8'd2);
    @(negedge clk);
    chk("R9 same-cycle data stored", data_rdata, 16'hBEEF);

    scen = "R3 command on completion edge";
    while (!(m_active && m_t == m_total - 1)) @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = mk(1, 0, 5'd2, 5'd2);
    @(negedge clk);
    cmd_we = 1'b0;
    chk("R3 completion-edge command ignored", 16'(busy), 16'd0);
    repeat (4) @(negedge clk);
    chk("R3 still idle", 16'(busy), 16'd0);

    scen = "R5 suppressed write";
    issue(12'd0, 0, 1, 16'h0F0F, 0, '0);
    issue(mk(0, 1, 5'd21, 5'd10), 1, 0, '0, 0, '0);
    wait_idle();
    chk("R9 write keeps data", data_rdata, 16'h0F0F);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule